// File: doc/BRIEF.md
# Interrupt Source Mask and Status Unit

This unit collects a bank of raw interrupt lines. Each line has its own polarity bit and its own detection type, level or edge. Detected events are kept in one status bit per source. Each status bit is gated by an enable bit for that source. A fixed-priority encoder selects the lowest-numbered source that is both enabled and pending. It reports that source as an 8-bit vector and drives a single combined interrupt line.

Software reaches the unit through a plain single-cycle register port. A write takes effect at the clock edge where `reg_wr_i` is high, and a read is combinational from `reg_addr_i`. The port has no back-pressure: every write is accepted. Enables and status are never written directly. Each has a set register and a clear register, so several agents can update single bits without a read-modify-write. An end-of-interrupt register accepts a vector. For an edge-type source, writing that source's vector acknowledges it.

Top module: `irq_msu`

## Requirements
- R1: The address is {group[2:0], word}. A source n uses word n/32 and bit n%32. The groups are: 0 enable-set, 1 enable-clear, 2 status-set, 3 status-clear, 4 polarity, 5 type, 6 vector (read only), 7 end-of-interrupt. Groups 0 and 1 read back the enable word, and groups 2 and 3 read back the status word.
- R2: After reset all enables and status bits are 0, all polarity bits are 1, all type bits are 0, the end-of-interrupt value is 0, `irq_o` is 0 and `vec_o` is 8'hFF.
- R3: A write to enable-set sets the enables at the 1 bits. A write to enable-clear clears them. Bits written as 0 leave their enables unchanged.
- R4: A write to status-set forces the status bit of each 1 bit. A write to status-clear clears the status bit of each 1 bit, subject to R7.
- R5: The corrected input of a source equals the raw line when its polarity bit is 1 (active high). It equals the inverted line when the polarity bit is 0 (active low).
- R6: For a source with type bit 1 (edge), status is set one clock after the corrected input changes from inactive to active. The status then stays set after the input falls. A rising event in the same cycle as a status-clear wins.
- R7: For a source with type bit 0 (level), status is 1 on the clock after any cycle in which the corrected input is active. A status-clear has no effect while the input is still active, and clears the bit once the input is inactive.
- R8: `irq_o` is 1 exactly when some source has both its status and its enable set. A pending source that is not enabled does not raise it.
- R9: `vec_o` (also read at group 6, bits 7:0) is the lowest-numbered enabled pending source, or 8'hFF when there is none.
- R10: A write to end-of-interrupt stores bits 7:0, and this value is read back at group 7. If the value names an edge-type source, that source's status is cleared. A value of NUM_SRC or above is only stored.
- R11: An end-of-interrupt write does not clear the status of a level-type source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Raw interrupt lines, synchronous to clk |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3+log2(NUM_SRC/32) | Register address {group, word} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Combined interrupt request |
| vec_o | output | 8 | Highest-priority pending vector, 8'hFF when idle |

## Verification
Some rules are checked on every cycle: agreement between `irq_o` and an idle vector, the winner being enabled, pending and lowest-numbered, the enable set and clear writes, level status holding while the input is active, edge capture, and end-of-interrupt clearing of edge sources. Only the bench scenarios show the rest. These are polarity inversion, a clear being refused on an active level source and then accepted, a rising edge beating a clear written in the same cycle, out-of-range vectors only being stored, register readback and the reset values.

// File: rtl/irq_msu_pkg.sv
package irq_msu_pkg;
  localparam int WORD_W = 32;
  localparam int VEC_W  = 8;
  localparam int GRP_W  = 3;

  typedef enum logic [GRP_W-1:0] {
    GRP_EN_SET = 3'd0,
    GRP_EN_CLR = 3'd1,
    GRP_ST_SET = 3'd2,
    GRP_ST_CLR = 3'd3,
    GRP_POL    = 3'd4,
    GRP_TYPE   = 3'd5,
    GRP_VEC    = 3'd6,
    GRP_EOI    = 3'd7
  } grp_e;
endpackage

// File: rtl/irq_msu_bank.sv
// One word of sources: detection, status and enable state.
module irq_msu_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] en_set_i,
  input  logic [W-1:0] en_clr_i,
  input  logic [W-1:0] st_set_i,
  input  logic [W-1:0] st_clr_i,
  input  logic [W-1:0] eoi_clr_i,
  input  logic         pol_we_i,
  input  logic         typ_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] st_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] typ_o,
  output logic [W-1:0] act_o
);
  logic [W-1:0] en_q, st_q, pol_q, typ_q, prev_q;
  logic [W-1:0] act, rise, st_edge, st_lvl, st_d, en_d;

  // polarity correction: 1 = active high, 0 = active low
  assign act     = ~(src_i ^ pol_q);
  assign rise    = act & ~prev_q;
  assign en_d    = (en_q | en_set_i) & ~en_clr_i;
  // edge: a new event or a forced set beats any clear in the same cycle
  assign st_edge = rise | st_set_i | (st_q & ~st_clr_i & ~eoi_clr_i);
  // level: an active input keeps the bit set regardless of clears
  assign st_lvl  = act | ((st_q | st_set_i) & ~st_clr_i);
  assign st_d    = (typ_q & st_edge) | (~typ_q & st_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      st_q   <= '0;
      pol_q  <= '1;
      typ_q  <= '0;
      prev_q <= '0;
    end else begin
      en_q   <= en_d;
      st_q   <= st_d;
      prev_q <= act;
      if (pol_we_i) pol_q <= wdata_i;
      if (typ_we_i) typ_q <= wdata_i;
    end
  end

  assign en_o  = en_q;
  assign st_o  = st_q;
  assign pol_o = pol_q;
  assign typ_o = typ_q;
  assign act_o = act;
endmodule

// File: rtl/irq_msu_prio.sv
// Fixed priority: lowest index wins; all-ones when nothing requests.
module irq_msu_prio #(
  parameter int N     = 64,
  parameter int IDX_W = 8
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_msu.sv
module irq_msu
  import irq_msu_pkg::*;
#(
  parameter  int NUM_SRC   = 64,
  localparam int NUM_WORDS = NUM_SRC / WORD_W,
  localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W    = GRP_W + WIDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [WORD_W-1:0]  reg_wdata_i,
  output logic [WORD_W-1:0]  reg_rdata_o,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  initial begin
    if (NUM_SRC % WORD_W != 0 || NUM_SRC > 255)
      $error("irq_msu: NUM_SRC must be a multiple of 32 and below 256");
  end

  grp_e              grp;
  logic [WIDX_W-1:0] widx;
  logic              widx_ok;
  logic              eoi_hit;
  logic [VEC_W-1:0]  eoi_vec;
  logic [VEC_W-1:0]  eoi_q;

  logic [NUM_SRC-1:0] en_all, st_all, pol_all, typ_all, act_all, pend;

  assign grp     = grp_e'(reg_addr_i[ADDR_W-1 -: GRP_W]);
  assign widx    = reg_addr_i[WIDX_W-1:0];
  assign widx_ok = int'(widx) < NUM_WORDS;
  assign eoi_hit = reg_wr_i && (grp == GRP_EOI);
  assign eoi_vec = reg_wdata_i[VEC_W-1:0];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic             sel;
    logic [WORD_W-1:0] en_set, en_clr, st_set, st_clr, eoi_clr;

    assign sel    = reg_wr_i && (int'(widx) == w);
    assign en_set = (sel && grp == GRP_EN_SET) ? reg_wdata_i : '0;
    assign en_clr = (sel && grp == GRP_EN_CLR) ? reg_wdata_i : '0;
    assign st_set = (sel && grp == GRP_ST_SET) ? reg_wdata_i : '0;
    assign st_clr = (sel && grp == GRP_ST_CLR) ? reg_wdata_i : '0;
    assign eoi_clr = (eoi_hit && int'(eoi_vec[VEC_W-1:5]) == w)
                     ? (WORD_W'(1) << eoi_vec[4:0]) : '0;

    irq_msu_bank #(.W(WORD_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i[w*WORD_W +: WORD_W]),
      .en_set_i  (en_set),
      .en_clr_i  (en_clr),
      .st_set_i  (st_set),
      .st_clr_i  (st_clr),
      .eoi_clr_i (eoi_clr),
      .pol_we_i  (sel && grp == GRP_POL),
      .typ_we_i  (sel && grp == GRP_TYPE),
      .wdata_i   (reg_wdata_i),
      .en_o      (en_all[w*WORD_W +: WORD_W]),
      .st_o      (st_all[w*WORD_W +: WORD_W]),
      .pol_o     (pol_all[w*WORD_W +: WORD_W]),
      .typ_o     (typ_all[w*WORD_W +: WORD_W]),
      .act_o     (act_all[w*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       eoi_q <= '0;
    else if (eoi_hit) eoi_q <= eoi_vec;
  end

  assign pend  = st_all & en_all;
  assign irq_o = |pend;

  irq_msu_prio #(.N(NUM_SRC), .IDX_W(VEC_W)) u_prio (
    .req_i (pend),
    .idx_o (vec_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (grp)
      GRP_EN_SET, GRP_EN_CLR:
        if (widx_ok) reg_rdata_o = en_all[int'(widx)*WORD_W +: WORD_W];
      GRP_ST_SET, GRP_ST_CLR:
        if (widx_ok) reg_rdata_o = st_all[int'(widx)*WORD_W +: WORD_W];
      GRP_POL:
        if (widx_ok) reg_rdata_o = pol_all[int'(widx)*WORD_W +: WORD_W];
      GRP_TYPE:
        if (widx_ok) reg_rdata_o = typ_all[int'(widx)*WORD_W +: WORD_W];
      GRP_VEC: reg_rdata_o = WORD_W'(vec_o);
      GRP_EOI: reg_rdata_o = WORD_W'(eoi_q);
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_msu_chk.sv
module irq_msu_chk #(
  parameter  int NUM_SRC   = 64,
  localparam int NUM_WORDS = NUM_SRC / 32,
  localparam int WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int ADDR_W    = 3 + WIDX_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [31:0]        reg_wdata_i,
  input logic               irq_o,
  input logic [7:0]         vec_o,
  input logic [NUM_SRC-1:0] en_all,
  input logic [NUM_SRC-1:0] st_all,
  input logic [NUM_SRC-1:0] typ_all,
  input logic [NUM_SRC-1:0] act_all
);
  logic [2:0]         grp;
  logic [WIDX_W-1:0]  widx;
  logic [NUM_SRC-1:0] act_prev;
  logic [NUM_SRC-1:0] pend;

  assign grp  = reg_addr_i[ADDR_W-1 -: 3];
  assign widx = reg_addr_i[WIDX_W-1:0];
  assign pend = st_all & en_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_prev <= '0;
    else        act_prev <= act_all;
  end

  // R8 / R9: combined line and idle vector agree
  a_r8_irq_has_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o != 8'hFF));
  a_r9_idle_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_o == 8'hFF));
  a_r9_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (st_all[int'(vec_o)] && en_all[int'(vec_o)]));
  a_r9_winner_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend & ~({NUM_SRC{1'b1}} << vec_o)) == '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && grp == 3'd0 && int'(widx) == i / 32 && reg_wdata_i[i % 32])
      |=> en_all[i]);
    a_r3_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && grp == 3'd1 && int'(widx) == i / 32 && reg_wdata_i[i % 32])
      |=> !en_all[i]);
    a_r7_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr_i && !typ_all[i] && act_all[i]) |=> st_all[i]);
    a_r6_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr_i && typ_all[i] && act_all[i] && !act_prev[i]) |=> st_all[i]);
    a_r10_eoi_clears_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && grp == 3'd7 && int'(reg_wdata_i[7:0]) == i && typ_all[i]
       && !(act_all[i] && !act_prev[i])) |=> !st_all[i]);
  end
endmodule

bind irq_msu irq_msu_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .vec_o       (vec_o),
  .en_all      (en_all),
  .st_all      (st_all),
  .typ_all     (typ_all),
  .act_all     (act_all)
);

// File: tb/irq_msu_tb_top.sv
module irq_msu_tb_top;
  localparam int NSRC = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [7:0]  vec;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2ns clk = ~clk;

  irq_msu #(.NUM_SRC(NSRC)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .vec_o       (vec)
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [63:0] src;
    logic        irq;
    logic [7:0]  vec;
    logic [7:0]  req;
  } row_t;

  // address = {group, word}: 0/1 en-set, 2/3 en-clr, 4/5 st-set,
  // 6/7 st-clr, 8/9 pol, A/B type, C vector, E eoi
  localparam int NROWS = 26;
  localparam row_t TBL [NROWS] = '{
    '{1'b0, 4'h0, 32'h0,        64'h0,           1'b0, 8'hFF, 8'd2 },  // R2 idle
    '{1'b1, 4'h0, 32'h21,       64'h0,           1'b0, 8'hFF, 8'd3 },  // R3 enable 0,5
    '{1'b0, 4'h0, 32'h0,        64'h20,          1'b1, 8'h05, 8'd7 },  // R7 level on 5
    '{1'b0, 4'h0, 32'h0,        64'h21,          1'b1, 8'h00, 8'd9 },  // R9 0 beats 5
    '{1'b0, 4'h0, 32'h0,        64'h0,           1'b1, 8'h00, 8'd7 },  // R7 held
    '{1'b1, 4'h6, 32'h1,        64'h0,           1'b1, 8'h05, 8'd4 },  // R4 clear 0
    '{1'b1, 4'h6, 32'h20,       64'h20,          1'b1, 8'h05, 8'd7 },  // R7 clear refused
    '{1'b1, 4'h6, 32'h20,       64'h0,           1'b0, 8'hFF, 8'd7 },  // R7 clear accepted
    '{1'b1, 4'hB, 32'h2,        64'h0,           1'b0, 8'hFF, 8'd6 },  // R6 33 edge type
    '{1'b1, 4'h1, 32'h2,        64'h0,           1'b0, 8'hFF, 8'd3 },  // R3 enable 33
    '{1'b0, 4'h0, 32'h0,        64'h2_0000_0000, 1'b1, 8'h21, 8'd6 },  // R6 rise
    '{1'b0, 4'h0, 32'h0,        64'h2_0000_0000, 1'b1, 8'h21, 8'd6 },  // R6 hold
    '{1'b1, 4'hE, 32'd33,       64'h2_0000_0000, 1'b0, 8'hFF, 8'd10},  // R10 eoi 33
    '{1'b0, 4'h0, 32'h0,        64'h0,           1'b0, 8'hFF, 8'd6 },  // R6 fall no event
    '{1'b0, 4'h0, 32'h0,        64'h2_0000_0000, 1'b1, 8'h21, 8'd6 },  // R6 rise again
    '{1'b0, 4'h0, 32'h0,        64'h0,           1'b1, 8'h21, 8'd6 },  // R6 latched
    '{1'b1, 4'h7, 32'h2,        64'h0,           1'b0, 8'hFF, 8'd4 },  // R4 clear 33
    '{1'b1, 4'h9, 32'hFFFFFFFB, 64'h0,           1'b0, 8'hFF, 8'd8 },  // R8 34 low-active
    '{1'b1, 4'h1, 32'h4,        64'h0,           1'b1, 8'h22, 8'd5 },  // R5 low line = active
    '{1'b1, 4'h7, 32'h4,        64'h4_0000_0000, 1'b0, 8'hFF, 8'd5 },  // R5 high line idle
    '{1'b1, 4'h4, 32'h100,      64'h4_0000_0000, 1'b0, 8'hFF, 8'd8 },  // R8 masked pend
    '{1'b1, 4'h0, 32'h100,      64'h4_0000_0000, 1'b1, 8'h08, 8'd3 },  // R3 enable 8
    '{1'b1, 4'h2, 32'h100,      64'h4_0000_0000, 1'b0, 8'hFF, 8'd3 },  // R3 disable 8
    '{1'b1, 4'h4, 32'h20,       64'h4_0000_0000, 1'b1, 8'h05, 8'd4 },  // R4 force 5
    '{1'b1, 4'hE, 32'd5,        64'h4_0000_0000, 1'b1, 8'h05, 8'd11},  // R11 eoi on level
    '{1'b1, 4'h6, 32'h20,       64'h4_0000_0000, 1'b0, 8'hFF, 8'd4 }   // R4 clear 5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d,
                      input logic [63:0] s);
    wr = w; addr = a; wdata = d; src = s;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    wr = 1'b0; addr = a;
    #1ns;
    v = rdata;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    check("R2 irq", 32'(irq), 32'h0);
    check("R2 vec", 32'(vec), 32'hFF);
    rd(4'h0, v); check("R2 enable w0", v, 32'h0);
    rd(4'h8, v); check("R2 polarity w0", v, 32'hFFFF_FFFF);
    rd(4'hB, v); check("R2 type w1", v, 32'h0);
    rd(4'hE, v); check("R2 eoi", v, 32'h0);

    for (int i = 0; i < NROWS; i++) begin
      step(TBL[i].wr, TBL[i].addr, TBL[i].data, TBL[i].src);
      check($sformatf("R%0d row %0d irq", TBL[i].req, i), 32'(irq), 32'(TBL[i].irq));
      check($sformatf("R%0d row %0d vec", TBL[i].req, i), 32'(vec), 32'(TBL[i].vec));
    end

    // R1 / R3 readback through the map
    rd(4'h0, v); check("R3 enable w0", v, 32'h21);
    rd(4'h3, v); check("R1 enable w1 via clear group", v, 32'h6);
    rd(4'h4, v); check("R4 status w0", v, 32'h100);
    rd(4'h5, v); check("R1 status w1", v, 32'h0);
    rd(4'h9, v); check("R5 polarity w1", v, 32'hFFFF_FFFB);
    rd(4'hB, v); check("R6 type w1", v, 32'h2);
    rd(4'hE, v); check("R10 eoi readback", v, 32'd5);

    // R10 out-of-range vector is only stored
    step(1'b1, 4'hE, 32'd200, 64'h4_0000_0000);
    rd(4'hE, v); check("R10 eoi 200 stored", v, 32'd200);
    rd(4'h4, v); check("R10 eoi 200 status kept", v, 32'h100);

    // R9 vector register
    step(1'b1, 4'h4, 32'h1, 64'h4_0000_0000);
    rd(4'hC, v); check("R9 vector read 0", v, 32'h0);
    step(1'b1, 4'h6, 32'h1, 64'h4_0000_0000);
    rd(4'hC, v); check("R9 vector read idle", v, 32'hFF);

    // R2 reset mid-run
    src = '0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R2 irq after reset", 32'(irq), 32'h0);
    check("R2 vec after reset", 32'(vec), 32'hFF);
    rd(4'h1, v); check("R2 enable w1 after reset", v, 32'h0);
    rd(4'h9, v); check("R2 polarity w1 after reset", v, 32'hFFFF_FFFF);
    rd(4'hE, v); check("R2 eoi after reset", v, 32'h0);

    // R6 corner: rise in the same cycle as a status clear
    step(1'b1, 4'hB, 32'h2, 64'h0);
    step(1'b1, 4'h1, 32'h2, 64'h0);
    step(1'b1, 4'h7, 32'h2, 64'h2_0000_0000);
    check("R6 rise beats clear irq", 32'(irq), 32'h1);
    check("R6 rise beats clear vec", 32'(vec), 32'h21);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule